// File: doc/BRIEF.md
# Fixed-Point Exponential and Logarithm Evaluator

This block is a sequential arithmetic unit. On request it computes either e^X or the natural logarithm of X for a signed 36-bit fixed-point argument. It is meant to sit beside a fast sampling pipeline, such as a rejection-based random variate generator, where these functions are needed only rarely. Speed is therefore traded for area: one 18×18 signed multiplier and a small coefficient ROM are reused across every step, and a one-hot state machine sequences them.

For e^X, an integer k is chosen first so that the reduced argument x = X − k·ln2 lies near [−ln2/2, +ln2/2]. A degree-5 polynomial P is then evaluated by Horner's rule, and e^x is formed as P(x)·x² + x + 1. The result is scaled by 2^k with an arithmetic shift that saturates. For ln X, a leading-one search normalises X to a mantissa. The mantissa is folded into [√½, √2), a Horner series in z = mantissa − 1 follows, and k·ln2 is added back.

A caller raises `start` for one cycle with `op_ln` and `arg`, waits while `busy` is high, and takes `result` in the cycle in which `done` pulses.

Top module: `fx_explog_unit`

## Requirements
- R1: `arg` and `result` are two's-complement values with 15 fraction bits, so 1.0 is encoded as 32768. `op_ln` = 0 selects e^X and `op_ln` = 1 selects ln X.
- R2: For an e^X request with −24 ≤ X ≤ 24 whose true result is below 2^35 − 1 LSB, `result` is within 2 LSB plus 1/4096 of the true value.
- R3: For an e^X request, `result` is 2^35 − 1 if X > 24 or if the true value reaches 2^35 − 1 LSB, and it is 0 if X < −24. An e^X result is never negative.
- R4: For an ln X request with X > 0, `result` is within 8 LSB of the true natural logarithm.
- R5: For an ln X request with X ≤ 0, `result` is −2^35.
- R6: Counting the clock edge that accepts `start` as edge 0, `done` is high after edge 19 for e^X with |X| ≤ 24. It is high after edge 27 for ln X with X > 0. It is high after edge 1 for every other request.
- R7: `done` is high for exactly one cycle. `busy` is high from the edge that accepts a request until `done` rises, and `busy` is low while `done` is high.
- R8: A `start` that arrives while `busy` is high is ignored. The running request completes with its own result and latency, and no extra `done` pulse follows.
- R9: After a synchronous reset, `busy`, `done` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| op_ln | input | 1 | 0 = exponential, 1 = natural logarithm |
| arg | input | 36 | Signed argument, 15 fraction bits |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | 36 | Signed result, 15 fraction bits, held until the next request completes |

## Verification
A wrong internal state shows at the ports in one of two ways. If the control sequence goes wrong (a skipped or repeated Horner step, a bad loop exit, a lost state bit), `done` arrives at the wrong edge, so measuring the latency of every request exposes the fault as soon as that request completes. If the arithmetic goes wrong (a bad coefficient, a k off by one, an incorrect fold of the mantissa, a shift that does not saturate), `result` misses the real-valued reference on the same request. Arguments that exercise the exact saturation and sign boundaries, the smallest and largest positive logarithm inputs, and a start strobe given in the middle of a request show a fault within one request.

// File: rtl/fx_explog_pkg.sv
package fx_explog_pkg;
  localparam int DW   = 36;          // data and accumulator width
  localparam int FB   = 15;          // fraction bits of arg and result
  localparam int MW   = DW / 2;      // multiplier operand width
  localparam int KW   = 8;           // exponent k width
  localparam int CAW  = 5;           // coefficient ROM address width
  localparam int NST  = 12;          // number of one-hot states

  // Scaled constants
  localparam int LOG2E_Q15    = 47275;  // log2(e) * 2^15
  localparam int LN2_Q17      = 90852;  // ln(2)   * 2^17
  localparam int HALF_LN2_Q15 = 11357;  // ln(2)/2 * 2^15
  localparam int TS_SH        = 3;      // pre-shift of argument before k estimate
  localparam int LN2_SH       = 2;      // LN2_Q17 -> Q15

  // ROM layout: exp coefficients highest order first, then ln series
  localparam int EXP_FIRST = 0;
  localparam int EXP_LAST  = 5;
  localparam int LN_FIRST  = 6;
  localparam int LN_LAST   = 16;

  typedef enum int {
    S_IDLE  = 0,
    S_RED   = 1,
    S_KEXP  = 2,
    S_KLN   = 3,
    S_PRE   = 4,
    S_HINIT = 5,
    S_FETCH = 6,
    S_MAC   = 7,
    S_SQ1   = 8,
    S_SQ2   = 9,
    S_FIN   = 10,
    S_SCALE = 11
  } st_idx_e;
endpackage

// File: rtl/fx_coef_rom.sv
module fx_coef_rom #(
  parameter int AW = 5,
  parameter int W  = 18
) (
  input  logic                clk,
  input  logic [AW-1:0]       addr,
  output logic signed [W-1:0] q
);
  // Q3.15 coefficients; registered read so the table maps to block ROM
  function automatic logic signed [W-1:0] coef(input logic [AW-1:0] a);
    case (a)
      5'd0:    coef = W'(7);        // exp P: x^5
      5'd1:    coef = W'(46);       // x^4
      5'd2:    coef = W'(273);      // x^3
      5'd3:    coef = W'(1365);     // x^2
      5'd4:    coef = W'(5461);     // x^1
      5'd5:    coef = W'(16384);    // x^0
      5'd6:    coef = W'(2979);     // ln series: 1/11
      5'd7:    coef = -W'(3277);    // -1/10
      5'd8:    coef = W'(3641);     // 1/9
      5'd9:    coef = -W'(4096);    // -1/8
      5'd10:   coef = W'(4681);     // 1/7
      5'd11:   coef = -W'(5461);    // -1/6
      5'd12:   coef = W'(6554);     // 1/5
      5'd13:   coef = -W'(8192);    // -1/4
      5'd14:   coef = W'(10923);    // 1/3
      5'd15:   coef = -W'(16384);   // -1/2
      5'd16:   coef = W'(32768);    // 1
      default: coef = '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    q <= coef(addr);
  end
endmodule

// File: rtl/fx_lead_one.sv
module fx_lead_one #(
  parameter int W  = 35,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  v,
  output logic [PW-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (v[i]) pos = PW'(i);
    end
  end
endmodule

// File: rtl/fx_mul.sv
module fx_mul #(
  parameter int W = 18
) (
  input  logic signed [W-1:0]   a,
  input  logic signed [W-1:0]   b,
  output logic signed [2*W-1:0] p
);
  assign p = a * b;
endmodule

// File: rtl/fx_explog_unit.sv
module fx_explog_unit
  import fx_explog_pkg::*;
#(
  parameter int EXP_LIM_INT = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_ln,
  input  logic [DW-1:0] arg,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result
);
  localparam int WW  = 2 * DW;
  localparam int PW  = $clog2(DW - 1);
  localparam int NSH = DW - 1 - FB;          // Q(DW-1) mantissa -> Q(FB)
  localparam int KSH = 2 * FB - TS_SH;       // product scale of k estimate
  localparam logic signed [DW-1:0] RES_MAX  = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] RES_MIN  = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] EXP_HI   = DW'(longint'(EXP_LIM_INT) << FB);
  localparam logic signed [DW-1:0] EXP_LO   = -EXP_HI;
  localparam logic signed [DW-1:0] RND_F    = DW'(64'd1 << (FB - 1));
  localparam logic signed [DW-1:0] ONE_2F   = DW'(64'd1 << (2 * FB));
  localparam logic signed [DW-1:0] ONE_F    = DW'(64'd1 << FB);
  localparam logic [DW-1:0] SQRT_HALF = DW'(longint'(0.7071067811865476 * (2.0 ** (DW - 1))));

  logic [NST-1:0]         st, nxt;
  logic                   op_q;
  logic signed [DW-1:0]   arg_q;
  logic signed [MW-1:0]   xreg;
  logic signed [KW-1:0]   kreg;
  logic signed [DW-1:0]   kln2;
  logic signed [DW-1:0]   acc;
  logic [CAW-1:0]         cidx;

  logic signed [MW-1:0]   coef_q;
  logic [PW-1:0]          lead_pos;
  logic signed [MW-1:0]   mul_a, mul_b;
  logic signed [DW-1:0]   prod;

  logic [DW-1:0]          norm;
  logic                   fold;
  logic signed [KW-1:0]   k_ln;
  logic signed [DW-1:0]   z_full;
  logic signed [DW-1:0]   t_full;
  logic signed [DW-1:0]   kln2_w;
  logic signed [DW-1:0]   acc_rnd;
  logic signed [DW-1:0]   coef_ext, x_ext;
  logic                   red_exit;
  logic signed [DW-1:0]   red_val;
  logic [DW-1:0]          exp_res;
  logic [CAW-1:0]         c_last;

  // ---------------- shared resources ----------------
  fx_coef_rom #(.AW(CAW), .W(MW)) u_rom (.clk(clk), .addr(cidx), .q(coef_q));
  fx_lead_one #(.W(DW - 1), .PW(PW)) u_lead (.v(arg_q[DW-2:0]), .pos(lead_pos));
  fx_mul #(.W(MW)) u_mul (.a(mul_a), .b(mul_b), .p(prod));

  // ---------------- range reduction datapath ----------------
  always_comb begin
    norm   = {1'b0, arg_q[DW-2:0]} << (DW - 2 - int'(lead_pos));
    fold   = norm < SQRT_HALF;
    k_ln   = KW'(fold ? (int'(lead_pos) - FB) : (int'(lead_pos) + 1 - FB));
    z_full = fold ? $signed((norm + DW'(64'd1 << (NSH - 2))) >> (NSH - 1))
                  : $signed((norm + DW'(64'd1 << (NSH - 1))) >> NSH);
    z_full = z_full - ONE_F;
    t_full = arg_q + DW'(HALF_LN2_Q15);
  end

  always_comb begin
    acc_rnd  = (acc + RND_F) >>> FB;
    coef_ext = {{(DW-MW){coef_q[MW-1]}}, coef_q};
    x_ext    = {{(DW-MW){xreg[MW-1]}}, xreg};
    kln2_w   = (prod + DW'(2)) >>> LN2_SH;
    c_last   = op_q ? CAW'(LN_LAST) : CAW'(EXP_LAST);
  end

  // operand selection for the single multiplier
  always_comb begin
    unique case (1'b1)
      st[S_KEXP]: begin
        mul_a = MW'(t_full >>> TS_SH);
        mul_b = MW'(LOG2E_Q15);
      end
      st[S_KLN]: begin
        mul_a = {{(MW-KW){kreg[KW-1]}}, kreg};
        mul_b = MW'(LN2_Q17);
      end
      default: begin
        mul_a = MW'(acc_rnd);
        mul_b = xreg;
      end
    endcase
  end

  // early exits decided right after the argument is latched
  always_comb begin
    if (op_q) begin
      red_exit = arg_q <= 0;
      red_val  = RES_MIN;
    end else begin
      red_exit = (arg_q > EXP_HI) || (arg_q < EXP_LO);
      red_val  = (arg_q > EXP_HI) ? RES_MAX : '0;
    end
  end

  // 2^k reconstruction with saturation (acc holds e^x in Q2F, positive)
  always_comb begin
    int         shv;
    logic [WW-1:0] wide;
    shv     = int'(kreg) - FB;
    wide    = '0;
    exp_res = '0;
    if (shv >= 0) begin
      wide = {{DW{1'b0}}, acc} << shv;
      exp_res = (wide > {{DW{1'b0}}, RES_MAX}) ? RES_MAX : wide[DW-1:0];
    end else if (-shv < WW - 1) begin
      wide = ({{DW{1'b0}}, acc} + (WW'(1) << (-shv - 1))) >> (-shv);
      exp_res = wide[DW-1:0];
    end
  end

  // ---------------- one-hot control ----------------
  always_comb begin
    nxt = '0;
    unique case (1'b1)
      st[S_IDLE]:  nxt[start ? S_RED : S_IDLE] = 1'b1;
      st[S_RED]:   nxt[red_exit ? S_IDLE : (op_q ? S_KLN : S_KEXP)] = 1'b1;
      st[S_KEXP]:  nxt[S_KLN] = 1'b1;
      st[S_KLN]:   nxt[S_PRE] = 1'b1;
      st[S_PRE]:   nxt[S_HINIT] = 1'b1;
      st[S_HINIT]: nxt[S_FETCH] = 1'b1;
      st[S_FETCH]: nxt[S_MAC] = 1'b1;
      st[S_MAC]:   nxt[(cidx == c_last) ? S_SQ1 : S_FETCH] = 1'b1;
      st[S_SQ1]:   nxt[op_q ? S_FIN : S_SQ2] = 1'b1;
      st[S_SQ2]:   nxt[S_FIN] = 1'b1;
      st[S_FIN]:   nxt[S_SCALE] = 1'b1;
      st[S_SCALE]: nxt[S_IDLE] = 1'b1;
      default:     nxt[S_IDLE] = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= NST'(1) << S_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      op_q   <= 1'b0;
      arg_q  <= '0;
      xreg   <= '0;
      kreg   <= '0;
      kln2   <= '0;
      acc    <= '0;
      cidx   <= '0;
    end else begin
      st   <= nxt;
      done <= 1'b0;
      unique case (1'b1)
        st[S_IDLE]: if (start) begin
          op_q  <= op_ln;
          arg_q <= arg;
          busy  <= 1'b1;
        end
        st[S_RED]: begin
          if (red_exit) begin
            result <= red_val;
            done   <= 1'b1;
            busy   <= 1'b0;
          end else if (op_q) begin
            xreg <= MW'(z_full);
            kreg <= k_ln;
          end
        end
        st[S_KEXP]: kreg <= KW'(prod >>> KSH);
        st[S_KLN]: begin
          kln2 <= kln2_w;
          if (!op_q) xreg <= MW'(arg_q - kln2_w);
          cidx <= op_q ? CAW'(LN_FIRST) : CAW'(EXP_FIRST);
        end
        st[S_HINIT]: begin
          acc  <= coef_ext <<< FB;
          cidx <= cidx + 1'b1;
        end
        st[S_MAC]: begin
          acc <= prod + (coef_ext <<< FB);
          if (cidx != c_last) cidx <= cidx + 1'b1;
        end
        st[S_SQ1], st[S_SQ2]: acc <= prod;
        st[S_FIN]: acc <= op_q ? acc + (kln2 <<< FB)
                               : acc + (x_ext <<< FB) + ONE_2F;
        st[S_SCALE]: begin
          result <= op_q ? acc_rnd : exp_res;
          done   <= 1'b1;
          busy   <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_onehot_state_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(st) == 1);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_on_done_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(arg_q) && $stable(op_q)));

  assert_exp_nonneg_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !op_q) |-> !result[DW-1]);

  assert_ln_nonpos_R5: assert property (@(posedge clk) disable iff (rst)
    (done && op_q && (arg_q <= 0)) |-> (result == RES_MIN));
endmodule

// File: tb/sim_fx_explog_unit.sv
`timescale 1ns/1ps
module sim_fx_explog_unit;
  localparam longint MAXV = 64'sd34359738367;
  localparam longint MINV = -64'sd34359738368;
  localparam longint LIM  = 64'sd24 * 32768;

  logic        clk = 1'b0;
  logic        rst, start, op_ln;
  logic [35:0] arg;
  logic        busy, done;
  logic [35:0] result;
  int errors = 0;
  int checks = 0;
  int unsigned seed_sink;

  always #10 clk = ~clk;   // 50 MHz

  fx_explog_unit u0 (.clk(clk), .rst(rst), .start(start), .op_ln(op_ln),
                     .arg(arg), .busy(busy), .done(done), .result(result));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic longint exp_ref(input longint x);
    real r;
    if (x > LIM) return MAXV;
    if (x < -LIM) return 0;
    r = $exp(real'(x) / 32768.0) * 32768.0;
    if (r >= 34359738367.0) return MAXV;
    return longint'(r);
  endfunction

  function automatic longint ln_ref(input longint x);
    if (x <= 0) return MINV;
    return longint'($ln(real'(x) / 32768.0) * 32768.0);
  endfunction

  function automatic int lat_ref(input bit o, input longint x);
    if (o) return (x > 0) ? 27 : 1;
    return (x >= -LIM && x <= LIM) ? 19 : 1;
  endfunction

  // issue one request, measure edges to done, check result, latency, handshake
  task automatic run_op(input bit o, input longint x, input string tag);
    longint res, expv, diff, tol;
    int cyc;
    bit busy_mid;
    @(negedge clk);
    op_ln = o; arg = x[35:0]; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    busy_mid = busy;
    cyc = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done || cyc > 100) break;
    end
    res  = longint'($signed(result));
    expv = o ? ln_ref(x) : exp_ref(x);
    diff = (res > expv) ? res - expv : expv - res;
    if (o) tol = (x > 0) ? 8 : 0;
    else   tol = (expv == MAXV || x > LIM || x < -LIM) ? 0 : 2 + expv / 4096;
    check(diff <= tol, tag, o ? "ln value" : "exp value", res, expv);
    check(cyc == lat_ref(o, x), "R6", "latency", cyc, lat_ref(o, x));
    check(!busy, "R7", "busy low with done", busy, 0);
    if (lat_ref(o, x) > 1) check(busy_mid == 1'b1, "R7", "busy while working", busy_mid, 1);
    @(negedge clk);
    check(!done, "R7", "done single pulse", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R6 actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    seed_sink = $urandom(32'd20240611);
    rst = 1'b1; start = 1'b0; op_ln = 1'b0; arg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check(busy == 1'b0, "R9", "busy after reset", busy, 0);
    check(done == 1'b0, "R9", "done after reset", done, 0);
    check(result == '0, "R9", "result after reset", longint'(result), 0);
    rst = 1'b0;

    // R1: encoding, 1.0 == 32768 both ways
    run_op(1'b0, 0, "R1");                   // e^0 = 1.0
    run_op(1'b1, 32768, "R1");               // ln 1 = 0
    // R2 directed
    run_op(1'b0, 32768, "R2");
    run_op(1'b0, -64'sd12 * 32768, "R2");
    run_op(1'b0, LIM, "R2");                 // boundary, computed path, saturates
    run_op(1'b0, -LIM, "R2");                // boundary, underflows to 0
    // R3 saturation and early exits
    run_op(1'b0, LIM + 1, "R3");
    run_op(1'b0, -LIM - 1, "R3");
    run_op(1'b0, 64'sd20 * 32768, "R3");
    // R4 directed
    run_op(1'b1, 65536, "R4");
    run_op(1'b1, 1, "R4");                   // smallest positive
    run_op(1'b1, MAXV, "R4");                // largest positive
    run_op(1'b1, 23170, "R4");               // near the fold point
    // R5 non-positive logarithm
    run_op(1'b1, 0, "R5");
    run_op(1'b1, -64'sd5 * 32768, "R5");
    run_op(1'b1, MINV, "R5");

    // R2 random
    for (int i = 0; i < 30; i++) begin
      longint x;
      x = longint'($urandom_range(0, 26 * 32768)) - 64'sd12 * 32768;
      run_op(1'b0, x, "R2");
    end
    // R4 random across magnitudes
    for (int i = 0; i < 30; i++) begin
      longint x, m;
      int p;
      p = int'($urandom_range(0, 34));
      m = {$urandom, $urandom};
      x = (m & ((64'sd1 <<< p) - 1)) | (64'sd1 <<< p);
      run_op(1'b1, x, "R4");
    end

    // R8: start while busy is ignored
    begin
      int cyc;
      longint res, expv, diff;
      int extra;
      @(negedge clk);
      op_ln = 1'b0; arg = 36'd32768; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (1) begin
        @(posedge clk);
        cyc++;
        @(negedge clk);
        if (cyc == 4) begin
          op_ln = 1'b1; arg = 36'hF_FFFF_0000; start = 1'b1;
        end else begin
          start = 1'b0;
        end
        if (done || cyc > 100) break;
      end
      res  = longint'($signed(result));
      expv = exp_ref(32768);
      diff = (res > expv) ? res - expv : expv - res;
      check(diff <= 2 + expv / 4096, "R8", "value of running request", res, expv);
      check(cyc == 19, "R8", "latency of running request", cyc, 19);
      extra = 0;
      repeat (40) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R8", "no extra done", extra, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule